// File: doc/BRIEF.md
# Fuse Controller Register Block

This block is the bus-facing front end of a one-time-programmable fuse array. Software reaches it through a small register map. A control word holds a fuse word address, an unlock key field and three status flags, and it has separate alias addresses that set or clear bits. The map also has a free timing register, a program data register, and a window of shadow registers that hold a copy of every fuse word. The block does not touch the fuses itself. It hands program and shadow-reload jobs to a fuse engine over a level request that the engine ends with a one-cycle done pulse.

Burning a fuse word takes two steps. Software first writes the unlock key and the target address into the control word, which can be done in one bus write. It then writes the data register. The block enforces a lock and error policy. A dedicated lock fuse word, captured during every shadow reload, write-locks and read-locks groups of words. Any illegal or overlapping access raises a sticky error flag. While that flag is up, no new program, read or reload can start until software clears it through the clear alias.

Top module: `fuse_ctl_regs`

## Requirements
- R1: After reset the control word reads 0, the timing register reads its reset parameter (0 by default), and the engine request is low.
- R2: The control word reads as {key[31:16], 5'b0, reloading[10], error[9], busy[8], address[7:0]}. A write to offset 0x000 replaces the key and address fields. A write to 0x004 ORs bits into those fields, and a write to 0x008 clears bits in them. Status bits are never written directly. The timing register at 0x010 reads back what was written. The data register at 0x020 reads back its last accepted value.
- R3: A data write starts a burn when the key field equals 0x3E77, the block is neither busy nor in error, the address is below 128 and the word is not write-locked. From the next cycle: busy reads 1, the key field reads 0, and the engine request is high with op 0, the latched address and the written data.
- R4: During a burn, writes to the address field show in the control word but do not change the engine address or data. The engine done pulse clears busy in the following cycle.
- R5: A data write while busy is ignored. The data register and the engine data stay unchanged and no error is raised.
- R6: A keyed data write to an address of 128 or more, or to a write-locked word, issues no engine request and leaves busy at 0. It sets error and clears the key field.
- R7: Word 127 is the lock word and is captured when a reload loads it. Bit g (g = 0..15) write-locks words 8g to 8g+7. Bit 16+g read-locks the same words.
- R8: Reading a read-locked shadow word returns 0xBADABADA and sets error.
- R9: Shadow word i sits at 0x400 + 0x10*i, and reads return data one cycle after the read strobe. A shadow write stores the data, unless a reload is running or the word is write-locked. In those two cases the shadow is unchanged and error is set.
- R10: While error is set, a keyed data write starts nothing and keeps the key, a reload request is ignored, and shadow reads return 0. Writing bit 9 to the clear alias clears error.
- R11: Writing bit 10 to the set alias starts a reload. The reloading bit reads 1 and the engine request is high with op 1. Every engine load is copied into the shadows, and the done pulse clears the reloading bit.
- R12: A reload request while busy or reloading, or a keyed data write while reloading, is refused and sets error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| eng_req | output | 1 | Job request to the fuse engine, held until done |
| eng_op | output | 1 | Job kind: 0 burn, 1 shadow reload |
| eng_addr | output | 7 | Word to burn |
| eng_wdata | output | 32 | Bits to burn |
| eng_done | input | 1 | One-cycle job completion pulse |
| eng_ld_we | input | 1 | Reload data valid |
| eng_ld_idx | input | 7 | Word index of reload data |
| eng_ld_data | input | 32 | Fuse word contents during reload |

## Verification
The sharpest collision is a software write to a shadow word in the very cycle the engine pulses done to end a reload. In that cycle the reload is still in progress, so the write must be refused with an error and the shadow must keep its reloaded value. The bench holds back the engine model's done pulse and then releases it on the same clock edge that carries the shadow write. It then checks that the error bit is set, that the reload bit has dropped, and that the word still reads its fuse value once the error is cleared.

// File: rtl/fuse_ctl_pkg.sv
package fuse_ctl_pkg;
   localparam int OFF_CTRL   = 'h000;
   localparam int OFF_SET    = 'h004;
   localparam int OFF_CLR    = 'h008;
   localparam int OFF_TIMING = 'h010;
   localparam int OFF_DATA   = 'h020;
   localparam int SH_BASE    = 'h400;
   localparam int SH_SHIFT   = 4;

   localparam int BIT_BUSY   = 8;
   localparam int BIT_ERR    = 9;
   localparam int BIT_RELOAD = 10;
   localparam int FADDR_W    = 8;

   localparam logic [15:0] UNLOCK_KEY  = 16'h3E77;
   localparam logic [31:0] RD_LOCK_VAL = 32'hBADA_BADA;

   typedef enum logic {
      ENG_PROG   = 1'b0,
      ENG_RELOAD = 1'b1
   } eng_op_e;
endpackage

// File: rtl/fuse_lock_table.sv
module fuse_lock_table #(
   parameter int NUM_WORDS   = 128,
   parameter int LOCK_GROUPS = 16,
   parameter int LOCK_IDX    = 127,
   localparam int IDX_W      = $clog2(NUM_WORDS),
   localparam int GRP_SHIFT  = $clog2(NUM_WORDS / LOCK_GROUPS)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_we,
   input  logic [IDX_W-1:0] ld_idx,
   input  logic [31:0]      ld_data,
   input  logic [IDX_W-1:0] acc_idx,
   input  logic [IDX_W-1:0] prog_idx,
   output logic             acc_wlocked,
   output logic             acc_rlocked,
   output logic             prog_wlocked
);
   logic [31:0]            lock_q;
   logic [LOCK_GROUPS-1:0] wlk;
   logic [LOCK_GROUPS-1:0] rlk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lock_q <= '0;
      else if (ld_we && (int'(ld_idx) == LOCK_IDX))
         lock_q <= ld_data;
   end

   for (genvar g = 0; g < LOCK_GROUPS; g++) begin : g_grp
      assign wlk[g] = lock_q[g];
      assign rlk[g] = lock_q[LOCK_GROUPS + g];
   end

   assign acc_wlocked  = wlk[acc_idx[IDX_W-1:GRP_SHIFT]];
   assign acc_rlocked  = rlk[acc_idx[IDX_W-1:GRP_SHIFT]];
   assign prog_wlocked = wlk[prog_idx[IDX_W-1:GRP_SHIFT]];
endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank #(
   parameter int NUM_WORDS = 128,
   localparam int IDX_W    = $clog2(NUM_WORDS)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_we,
   input  logic [IDX_W-1:0] ld_idx,
   input  logic [31:0]      ld_data,
   input  logic             sw_we,
   input  logic [IDX_W-1:0] sw_idx,
   input  logic [31:0]      sw_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [31:0]      rd_data
);
   logic [31:0] mem_q [NUM_WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= '0;
      end else if (ld_we) begin
         mem_q[ld_idx] <= ld_data;
      end else if (sw_we) begin
         mem_q[sw_idx] <= sw_data;
      end
   end

   assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/fuse_cmd_seq.sv
module fuse_cmd_seq #(
   parameter int NUM_WORDS = 128,
   localparam int IDX_W    = $clog2(NUM_WORDS)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_prog,
   input  logic             start_reload,
   input  logic [IDX_W-1:0] prog_addr,
   input  logic [31:0]      prog_data,
   input  logic             eng_done,
   output logic             busy,
   output logic             reloading,
   output logic             eng_req,
   output logic             eng_op,
   output logic [IDX_W-1:0] eng_addr,
   output logic [31:0]      eng_wdata
);
   import fuse_ctl_pkg::*;

   logic             busy_q, rld_q;
   logic [IDX_W-1:0] addr_q;
   logic [31:0]      data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         rld_q  <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else if (eng_done && (busy_q || rld_q)) begin
         busy_q <= 1'b0;
         rld_q  <= 1'b0;
      end else begin
         if (start_prog) begin
            busy_q <= 1'b1;
            addr_q <= prog_addr;
            data_q <= prog_data;
         end
         if (start_reload) rld_q <= 1'b1;
      end
   end

   assign busy      = busy_q;
   assign reloading = rld_q;
   assign eng_req   = busy_q | rld_q;
   assign eng_op    = rld_q ? ENG_RELOAD : ENG_PROG;
   assign eng_addr  = addr_q;
   assign eng_wdata = data_q;
endmodule

// File: rtl/fuse_ctl_regs.sv
module fuse_ctl_regs
   import fuse_ctl_pkg::*;
#(
   parameter int          NUM_WORDS   = 128,
   parameter int          LOCK_GROUPS = 16,
   parameter int          LOCK_IDX    = NUM_WORDS - 1,
   parameter int          ADDR_W      = 12,
   parameter logic [31:0] TIMING_RST  = 32'h0,
   localparam int         IDX_W       = $clog2(NUM_WORDS)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              eng_req,
   output logic              eng_op,
   output logic [IDX_W-1:0]  eng_addr,
   output logic [31:0]       eng_wdata,
   input  logic              eng_done,
   input  logic              eng_ld_we,
   input  logic [IDX_W-1:0]  eng_ld_idx,
   input  logic [31:0]       eng_ld_data
);
   localparam int LINE_W = ADDR_W - SH_SHIFT;
   localparam int LINE0  = SH_BASE >> SH_SHIFT;

   if ((NUM_WORDS % LOCK_GROUPS) != 0 || 2 * LOCK_GROUPS > 32)
      begin : g_bad_groups $error("lock grouping does not fit the lock word"); end
   if (SH_BASE + (NUM_WORDS << SH_SHIFT) > (1 << ADDR_W))
      begin : g_bad_addr $error("shadow window exceeds the address space"); end
   if (NUM_WORDS > (1 << FADDR_W))
      begin : g_bad_words $error("word count exceeds the address field"); end

   logic [FADDR_W-1:0] addr_q;
   logic [15:0]        unlock_q;
   logic               err_q;
   logic [31:0]        data_q, timing_q;
   logic               busy, reloading;

   // address decode
   logic [LINE_W-1:0] line;
   logic              sh_hit;
   logic [IDX_W-1:0]  sh_idx;
   assign line   = bus_addr[ADDR_W-1:SH_SHIFT];
   assign sh_hit = (bus_addr[SH_SHIFT-1:0] == '0) && (int'(line) >= LINE0)
                   && (int'(line) < LINE0 + NUM_WORDS);
   assign sh_idx = IDX_W'(int'(line) - LINE0);

   logic wr_ctrl, wr_set, wr_clr, wr_tim, wr_data, wr_sh, rd_sh;
   assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
   assign wr_set  = bus_we && (bus_addr == ADDR_W'(OFF_SET));
   assign wr_clr  = bus_we && (bus_addr == ADDR_W'(OFF_CLR));
   assign wr_tim  = bus_we && (bus_addr == ADDR_W'(OFF_TIMING));
   assign wr_data = bus_we && (bus_addr == ADDR_W'(OFF_DATA));
   assign wr_sh   = bus_we && sh_hit;
   assign rd_sh   = bus_re && sh_hit;

   // lock and shadow storage
   logic        ld_we_g, acc_wlocked, acc_rlocked, prog_wlocked;
   logic        sh_wr_ok;
   logic [31:0] sh_rdata;
   assign ld_we_g = eng_ld_we && reloading;

   fuse_lock_table #(.NUM_WORDS(NUM_WORDS), .LOCK_GROUPS(LOCK_GROUPS), .LOCK_IDX(LOCK_IDX)) u_lock (
      .clk(clk), .rst_n(rst_n), .ld_we(ld_we_g), .ld_idx(eng_ld_idx), .ld_data(eng_ld_data),
      .acc_idx(sh_idx), .prog_idx(addr_q[IDX_W-1:0]),
      .acc_wlocked(acc_wlocked), .acc_rlocked(acc_rlocked), .prog_wlocked(prog_wlocked));

   fuse_shadow_bank #(.NUM_WORDS(NUM_WORDS)) u_shadow (
      .clk(clk), .rst_n(rst_n), .ld_we(ld_we_g), .ld_idx(eng_ld_idx), .ld_data(eng_ld_data),
      .sw_we(sh_wr_ok), .sw_idx(sh_idx), .sw_data(bus_wdata),
      .rd_idx(sh_idx), .rd_data(sh_rdata));

   // policy
   logic unlocked, addr_ok, prog_try, start_prog, prog_fault;
   logic rl_try, start_reload, rl_fault, sh_wr_fault, rd_fault, err_set, err_clr;

   assign unlocked     = (unlock_q == UNLOCK_KEY);
   assign addr_ok      = int'(addr_q) < NUM_WORDS;
   assign prog_try     = wr_data && unlocked && !busy && !err_q;
   assign start_prog   = prog_try && !reloading && addr_ok && !prog_wlocked;
   assign prog_fault   = prog_try && (reloading || !addr_ok || prog_wlocked);
   assign rl_try       = wr_set && bus_wdata[BIT_RELOAD] && !err_q;
   assign start_reload = rl_try && !busy && !reloading;
   assign rl_fault     = rl_try && (busy || reloading);
   assign sh_wr_ok     = wr_sh && !reloading && !acc_wlocked;
   assign sh_wr_fault  = wr_sh && (reloading || acc_wlocked);
   assign rd_fault     = rd_sh && !err_q && acc_rlocked;
   assign err_set      = prog_fault | rl_fault | sh_wr_fault | rd_fault;
   assign err_clr      = wr_clr && bus_wdata[BIT_ERR];

   fuse_cmd_seq #(.NUM_WORDS(NUM_WORDS)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_reload(start_reload),
      .prog_addr(addr_q[IDX_W-1:0]), .prog_data(bus_wdata), .eng_done(eng_done),
      .busy(busy), .reloading(reloading), .eng_req(eng_req), .eng_op(eng_op),
      .eng_addr(eng_addr), .eng_wdata(eng_wdata));

   // control, data and timing registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         unlock_q <= '0;
         err_q    <= 1'b0;
         data_q   <= '0;
         timing_q <= TIMING_RST;
      end else begin
         if (wr_ctrl) begin
            addr_q   <= bus_wdata[FADDR_W-1:0];
            unlock_q <= bus_wdata[31:16];
         end else if (wr_set) begin
            addr_q   <= addr_q | bus_wdata[FADDR_W-1:0];
            unlock_q <= unlock_q | bus_wdata[31:16];
         end else if (wr_clr) begin
            addr_q   <= addr_q & ~bus_wdata[FADDR_W-1:0];
            unlock_q <= unlock_q & ~bus_wdata[31:16];
         end else if (prog_try) begin
            unlock_q <= '0;
         end
         if (err_set)      err_q <= 1'b1;
         else if (err_clr) err_q <= 1'b0;
         if (wr_data && !busy) data_q <= bus_wdata;
         if (wr_tim)           timing_q <= bus_wdata;
      end
   end

   // registered read port
   logic [31:0] ctrl_word;
   assign ctrl_word = {unlock_q, 5'b0, reloading, err_q, busy, addr_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_re) begin
         if (bus_addr == ADDR_W'(OFF_CTRL) || bus_addr == ADDR_W'(OFF_SET)
             || bus_addr == ADDR_W'(OFF_CLR))       bus_rdata <= ctrl_word;
         else if (bus_addr == ADDR_W'(OFF_TIMING)) bus_rdata <= timing_q;
         else if (bus_addr == ADDR_W'(OFF_DATA))   bus_rdata <= data_q;
         else if (sh_hit) begin
            if (err_q)            bus_rdata <= '0;
            else if (acc_rlocked) bus_rdata <= RD_LOCK_VAL;
            else                  bus_rdata <= sh_rdata;
         end else                 bus_rdata <= '0;
      end
   end
endmodule

// File: rtl/fuse_ctl_regs_chk.sv
module fuse_ctl_regs_chk #(
   parameter int IDX_W = 7
)(
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             reloading,
   input logic             err_q,
   input logic [15:0]      unlock_q,
   input logic             eng_req,
   input logic [IDX_W-1:0] eng_addr,
   input logic [31:0]      eng_wdata,
   input logic             eng_done
);
   // R12: a burn and a reload never run together
   p_single_job_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy, reloading}));

   // R3: the key is consumed when a burn begins
   p_key_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (unlock_q == 16'h0));

   // R4: the job presented to the engine holds until done
   p_job_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && $past(eng_req) && !$past(eng_done)) |-> ($stable(eng_addr) && $stable(eng_wdata)));

   // R10: no job starts out of an error state
   p_err_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eng_req) |-> !$past(err_q));

   // R11: done ends the request
   p_done_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && eng_req) |=> !eng_req);
endmodule

bind fuse_ctl_regs fuse_ctl_regs_chk #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .reloading(reloading), .err_q(err_q),
   .unlock_q(unlock_q), .eng_req(eng_req), .eng_addr(eng_addr),
   .eng_wdata(eng_wdata), .eng_done(eng_done));

// File: tb/fuse_ctl_regs_tb_top.sv
module fuse_ctl_regs_tb_top;
   localparam int NW   = 128;
   localparam int PLAT = 30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0, bus_re = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        eng_req, eng_op;
   logic [6:0]  eng_addr;
   logic [31:0] eng_wdata;
   logic        eng_done = 1'b0, eng_ld_we = 1'b0;
   logic [6:0]  eng_ld_idx = '0;
   logic [31:0] eng_ld_data = '0;

   int checks = 0, failures = 0;
   logic [31:0] fuse [NW];
   logic        allow_done = 1'b1;
   int          ecnt = 0;

   always #5 clk = ~clk;

   fuse_ctl_regs dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_req(eng_req), .eng_op(eng_op),
      .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_done(eng_done),
      .eng_ld_we(eng_ld_we), .eng_ld_idx(eng_ld_idx), .eng_ld_data(eng_ld_data));

   // behavioural fuse engine
   initial begin
      for (int i = 0; i < NW - 1; i++) fuse[i] = {i[7:0], ~i[7:0], 8'h5A, i[7:0]};
      fuse[NW-1] = 32'h0008_0004;  // write-lock group 2, read-lock group 3
      forever begin
         @(negedge clk);
         eng_done  = 1'b0;
         eng_ld_we = 1'b0;
         if (!eng_req) ecnt = 0;
         else begin
            ecnt++;
            if (eng_op == 1'b0) begin
               if (ecnt == PLAT) begin
                  fuse[eng_addr] = fuse[eng_addr] | eng_wdata;
                  eng_done = 1'b1;
               end
            end else if (ecnt <= NW) begin
               eng_ld_we   = 1'b1;
               eng_ld_idx  = 7'(ecnt - 1);
               eng_ld_data = fuse[ecnt-1];
            end else if (allow_done) eng_done = 1'b1;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bread(input logic [11:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_re = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_re = 1'b0;
      v = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 400; i++) begin
         bread(12'h000, v);
         if (v[8] == 1'b0 && v[10] == 1'b0) break;
      end
   endtask

   function automatic logic [11:0] sh(input int i);
      return 12'(32'h400 + 16 * i);
   endfunction

   typedef struct packed {
      logic [11:0] wa;
      logic [31:0] wd;
      logic [11:0] ra;
      logic [31:0] ex;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{12'h000, 32'h1234_00AB, 12'h000, 32'h1234_00AB},
      '{12'h004, 32'h0001_0010, 12'h000, 32'h1235_00BB},
      '{12'h008, 32'h0204_0003, 12'h000, 32'h1031_00B8},
      '{12'h000, 32'hFFFF_07FF, 12'h000, 32'hFFFF_00FF},
      '{12'h008, 32'hFFFF_00FF, 12'h000, 32'h0000_0000},
      '{12'h010, 32'h0612_A5C3, 12'h010, 32'h0612_A5C3},
      '{12'h020, 32'h5A5A_0001, 12'h020, 32'h5A5A_0001},
      '{12'h000, 32'h3E76_0005, 12'h000, 32'h3E76_0005},
      '{12'h020, 32'h0000_0001, 12'h000, 32'h3E76_0005},
      '{12'h000, 32'h0000_0000, 12'h000, 32'h0000_0000}
   };

   initial begin
      #200_000_000;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] exp5;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bread(12'h000, v); chk("R1 ctrl", v, 32'h0);
      bread(12'h010, v); chk("R1 timing", v, 32'h0);
      chk("R1 eng_req", {31'b0, eng_req}, 32'h0);

      // R2 alias table
      foreach (VECS[k]) begin
         bwrite(VECS[k].wa, VECS[k].wd);
         bread(VECS[k].ra, v);
         chk($sformatf("R2 vec%0d", k), v, VECS[k].ex);
      end

      // R11 reload, R7/R9 mapping
      bwrite(12'h004, 32'h0000_0400);
      bread(12'h000, v); chk("R11 reload bit", v, 32'h0000_0400);
      chk("R11 op", {eng_req, eng_op}, 32'h3);
      wait_idle();
      bread(12'h000, v); chk("R11 reload done", v, 32'h0);
      bread(sh(0), v);  chk("R9 word0", v, fuse[0]);
      bread(sh(40), v); chk("R9 word40", v, fuse[40]);
      bread(sh(127), v); chk("R7 lock word", v, 32'h0008_0004);

      // R3 burn of word 5, R4, R5
      exp5 = fuse[5] | 32'h0000_F00F;
      bwrite(12'h000, 32'h3E77_0005);
      bwrite(12'h020, 32'h0000_F00F);
      bread(12'h000, v); chk("R3 busy key cleared", v, 32'h0000_0105);
      chk("R3 req op", {eng_req, eng_op}, 32'h2);
      chk("R3 addr", {25'b0, eng_addr}, 32'h5);
      chk("R3 data", eng_wdata, 32'h0000_F00F);
      bwrite(12'h000, 32'h0000_0009);
      bread(12'h000, v); chk("R4 ctrl addr", v, 32'h0000_0109);
      chk("R4 eng addr held", {25'b0, eng_addr}, 32'h5);
      bwrite(12'h020, 32'hFFFF_FFFF);
      bread(12'h020, v); chk("R5 data kept", v, 32'h0000_F00F);
      chk("R5 eng data kept", eng_wdata, 32'h0000_F00F);
      bread(12'h000, v); chk("R5 no error", v, 32'h0000_0109);
      wait_idle();
      bread(12'h000, v); chk("R4 busy cleared", v, 32'h0000_0009);
      bwrite(12'h004, 32'h0000_0400);
      wait_idle();
      bread(sh(5), v); chk("R3 burned word", v, exp5);

      // R6 locked word and out of range
      bwrite(12'h000, 32'h3E77_0011);
      bwrite(12'h020, 32'h0000_0001);
      bread(12'h000, v); chk("R6 locked word", v, 32'h0000_0211);
      chk("R6 no req", {31'b0, eng_req}, 32'h0);
      bwrite(12'h008, 32'h0000_0200);
      bread(12'h000, v); chk("R10 clear", v, 32'h0000_0011);
      bwrite(12'h000, 32'h3E77_00C8);
      bwrite(12'h020, 32'h0000_0001);
      bread(12'h000, v); chk("R6 out of range", v, 32'h0000_02C8);
      bwrite(12'h000, 32'h0000_0000);
      bwrite(12'h008, 32'h0000_0200);

      // R8 read lock, R10 error blocking
      bread(sh(26), v); chk("R8 locked read", v, 32'hBADA_BADA);
      bread(12'h000, v); chk("R8 error set", v, 32'h0000_0200);
      bread(sh(0), v);  chk("R10 read blocked", v, 32'h0);
      bwrite(12'h000, 32'h3E77_0001);
      bwrite(12'h020, 32'h0000_0007);
      bread(12'h000, v); chk("R10 burn blocked", v, 32'h3E77_0201);
      chk("R10 no req", {31'b0, eng_req}, 32'h0);
      bwrite(12'h004, 32'h0000_0400);
      bread(12'h000, v); chk("R10 reload ignored", v, 32'h3E77_0201);
      bwrite(12'h008, 32'h3E77_0200);
      bread(12'h000, v); chk("R10 cleared", v, 32'h0000_0001);
      bread(sh(0), v);  chk("R10 read after clear", v, fuse[0]);

      // R9 shadow writes
      bwrite(sh(3), 32'hCAFE_0003);
      bread(sh(3), v); chk("R9 shadow write", v, 32'hCAFE_0003);
      bwrite(sh(16), 32'h1111_2222);
      bread(12'h000, v); chk("R9 locked write err", v, 32'h0000_0201);
      bwrite(12'h008, 32'h0000_0200);
      bread(sh(16), v); chk("R9 locked unchanged", v, fuse[16]);
      bwrite(12'h004, 32'h0000_0400);
      bwrite(sh(4), 32'h0000_DEAD);
      bread(12'h000, v); chk("R9 write in reload", v, 32'h0000_0601);
      wait_idle();
      bwrite(12'h008, 32'h0000_0200);
      bread(sh(4), v); chk("R9 reload kept word", v, fuse[4]);

      // R12 overlap refusals
      bwrite(12'h004, 32'h0000_0400);
      bwrite(12'h004, 32'h0000_0400);
      bread(12'h000, v); chk("R12 reload on reload", v, 32'h0000_0601);
      bwrite(12'h008, 32'h0000_0200);
      bwrite(12'h000, 32'h3E77_0006);
      bwrite(12'h020, 32'h0000_0001);
      bread(12'h000, v); chk("R12 burn in reload", v, 32'h0000_0606);
      wait_idle();
      bwrite(12'h008, 32'h0000_0200);
      bwrite(12'h000, 32'h3E77_0006);
      bwrite(12'h020, 32'h0100_0000);
      bwrite(12'h004, 32'h0000_0400);
      bread(12'h000, v); chk("R12 reload in burn", v, 32'h0000_0306);
      wait_idle();
      bwrite(12'h008, 32'h0000_0200);
      bread(12'h000, v); chk("R12 recovered", v, 32'h0000_0006);

      // R9/R11 shadow write on the reload's final cycle
      allow_done = 1'b0;
      bwrite(12'h004, 32'h0000_0400);
      repeat (140) @(negedge clk);
      bread(12'h000, v); chk("R11 held reload", v, 32'h0000_0406);
      @(posedge clk); #1 allow_done = 1'b1;
      bwrite(sh(2), 32'h7777_7777);
      bread(12'h000, v); chk("R9 same-cycle err", v, 32'h0000_0206);
      bwrite(12'h008, 32'h0000_0200);
      bread(sh(2), v); chk("R9 same-cycle word", v, fuse[2]);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule